// File: doc/BRIEF.md
# CAN Protocol Status Word Keeper

This block holds the protocol status word of a CAN controller. The bit-level engine sends it one-cycle strobes. These strobes report a detected error together with its 3-bit type, the error-free end of a transmitted or received message, and the moment a flexible-data-rate frame switches bit rate into its data phase. The block records the most recent bus event as a 3-bit code. Events that fall in the data phase go to a second code of the same form. The CPU sees both codes in one packed word, next to the registered node activity and the error-passive flag.

A CPU read of the word sets both codes to 7 ("nothing seen since the last read"). The value returned by the read is the value from before the reset. A message that completes without error clears the code that the event is routed to. When an event arrives in the same cycle as a read, the event wins, so no event is lost. A stuff error reported at a fixed stuff bit of the flexible-data-rate CRC field is recorded as a form error.

Top module: `can_proto_status`

## Requirements
- R1: After reset, both codes read 7, the activity field reads 00 (synchronizing) and the error-passive bit reads 0. That is, status_word = 9'b111_0_00_111.
- R2: An error strobe with code 1 (stuff), 2 (form), 3 (acknowledge), 4 (bit-1), 5 (bit-0) or 6 (CRC) stores that code in the main code, status_word[2:0]. The new value appears one cycle after the strobe.
- R3: A successful-transfer strobe sets the code it is routed to to 0.
- R4: A cpu_rd pulse sets both codes to 7 from the next cycle on. During the read cycle the word still shows the codes from before the read.
- R5: When an event and a read fall in the same cycle, the event's code is stored in the code it is routed to. The other code becomes 7.
- R6: After a dphase_start strobe, the next event (error or successful transfer) is written to the data-phase code, status_word[8:6]. The main code is left unchanged. Later events go back to the main code.
- R7: An error strobe with code 1 and err_fixed_stuff high is recorded as 2 (form error). For any other code, err_fixed_stuff has no effect.
- R8: status_word[4:3] shows node_act (00 synchronizing, 01 idle, 10 receiver, 11 transmitter) and status_word[5] shows err_passive (1 = error-passive). Both are one cycle delayed.
- R9: An error strobe carrying code 0 or 7 is ignored. It changes neither code, and it does not use up a pending data-phase routing.
- R10: If an error strobe and a successful-transfer strobe arrive together, the error code is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error event strobe |
| err_code | input | 3 | Error type for err_valid |
| err_fixed_stuff | input | 1 | Error lies at a fixed stuff bit of the FD CRC field |
| xfer_ok | input | 1 | Message sent or received without error |
| dphase_start | input | 1 | FD frame entered data phase with bit-rate switching |
| node_act | input | 2 | Current node activity |
| err_passive | input | 1 | Node is error-passive |
| cpu_rd | input | 1 | CPU read of the status word |
| status_word | output | 9 | {data code, error-passive, activity, main code} |

## Verification
On every cycle the assertions check the following. The activity and error-passive fields follow their inputs with a one-cycle delay. A read with no event leaves both codes at 7. With no strobe and no read, the codes stay stable. A transfer with no error produces a 0. A fixed-stuff stuff error never shows up as code 1. Other behaviour depends on the history of earlier strobes, so only the bench's scenarios can show it. This covers routing to the data-phase code and the return to the main code, collisions between an event and a read, the pre-read value seen during a read, and the rule that a code-0 or code-7 strobe does not consume a pending data-phase routing.

// File: rtl/can_proto_status.sv
module can_proto_status #(
  parameter int CODE_W = 3,
  parameter int ACT_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            err_valid,
  input  logic [CODE_W-1:0]               err_code,
  input  logic                            err_fixed_stuff,
  input  logic                            xfer_ok,
  input  logic                            dphase_start,
  input  logic [ACT_W-1:0]                node_act,
  input  logic                            err_passive,
  input  logic                            cpu_rd,
  output logic [2*CODE_W+ACT_W:0]         status_word
);
  localparam logic [CODE_W-1:0] C_NONE  = '0;
  localparam logic [CODE_W-1:0] C_STUFF = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_FORM  = CODE_W'(2);
  localparam logic [CODE_W-1:0] C_IDLE  = '1;

  logic [CODE_W-1:0] main_q, data_q;
  logic [ACT_W-1:0]  act_q;
  logic              ep_q, dp_q;

  wire err_hit = err_valid && (err_code != C_NONE) && (err_code != C_IDLE);
  wire hit     = err_hit || xfer_ok;
  wire [CODE_W-1:0] err_eff = (err_code == C_STUFF && err_fixed_stuff) ? C_FORM : err_code;
  wire [CODE_W-1:0] new_code = err_hit ? err_eff : C_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= C_IDLE;
      data_q <= C_IDLE;
      dp_q   <= 1'b0;
      act_q  <= '0;
      ep_q   <= 1'b0;
    end else begin
      if (hit && !dp_q)      main_q <= new_code;
      else if (cpu_rd)       main_q <= C_IDLE;
      if (hit && dp_q)       data_q <= new_code;
      else if (cpu_rd)       data_q <= C_IDLE;
      dp_q  <= (dp_q && !hit) || dphase_start;
      act_q <= node_act;
      ep_q  <= err_passive;
    end
  end

  assign status_word = {data_q, ep_q, act_q, main_q};
endmodule

module can_proto_status_chk #(
  parameter int CODE_W = 3,
  parameter int ACT_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    err_valid,
  input logic [CODE_W-1:0]       err_code,
  input logic                    err_fixed_stuff,
  input logic                    xfer_ok,
  input logic [ACT_W-1:0]        node_act,
  input logic                    err_passive,
  input logic                    cpu_rd,
  input logic [2*CODE_W+ACT_W:0] status_word
);
  localparam int MLO = 0;
  localparam int AHI = CODE_W + ACT_W - 1;
  localparam int EPB = CODE_W + ACT_W;
  localparam int DLO = CODE_W + ACT_W + 1;

  wire [CODE_W-1:0] main_c = status_word[CODE_W-1:MLO];
  wire [CODE_W-1:0] data_c = status_word[2*CODE_W+ACT_W:DLO];

  a_r8_activity_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_word[AHI:CODE_W] == $past(node_act) && status_word[EPB] == $past(err_passive));

  a_r4_read_sets_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !err_valid && !xfer_ok) |=> (main_c == '1 && data_c == '1));

  a_r9_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && !xfer_ok && !cpu_rd) |=> ($stable(main_c) && $stable(data_c)));

  a_r3_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !err_valid) |=> (main_c == '0 || data_c == '0));

  a_r7_fixed_stuff_form: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == CODE_W'(1) && err_fixed_stuff && !xfer_ok)
      |=> (main_c == CODE_W'(2) || data_c == CODE_W'(2)));
endmodule

bind can_proto_status can_proto_status_chk #(.CODE_W(CODE_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_code(err_code),
  .err_fixed_stuff(err_fixed_stuff), .xfer_ok(xfer_ok), .node_act(node_act),
  .err_passive(err_passive), .cpu_rd(cpu_rd), .status_word(status_word));

// File: tb/tb_can_proto_status.sv
module tb_can_proto_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 0, err_fixed_stuff = 0, xfer_ok = 0, dphase_start = 0, cpu_rd = 0, err_passive = 0;
  logic [2:0] err_code = 0;
  logic [1:0] node_act = 0;
  logic [8:0] status_word;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_proto_status dut (.*);

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic [2:0] act, input logic [2:0] exp);
    chk(req, {6'd0, act}, {6'd0, exp});
  endtask

  task automatic drive(input logic e, input logic [2:0] c, input logic f,
                       input logic ok, input logic rd, input logic dp);
    @(negedge clk);
    err_valid = e; err_code = c; err_fixed_stuff = f; xfer_ok = ok; cpu_rd = rd; dphase_start = dp;
    @(negedge clk);
    err_valid = 0; err_code = 0; err_fixed_stuff = 0; xfer_ok = 0; cpu_rd = 0; dphase_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset word", status_word, 9'b111_0_00_111);
  endtask

  task automatic t_codes();
    for (int c = 1; c <= 6; c++) begin
      drive(1, 3'(c), 0, 0, 0, 0);
      chk3("R2 main code", status_word[2:0], 3'(c));
    end
    chk3("R2 data code untouched", status_word[8:6], 3'd7);
  endtask

  task automatic t_ok();
    drive(1, 3'd1, 0, 0, 0, 0);
    drive(0, 3'd0, 0, 1, 0, 0);
    chk3("R3 ok clears main", status_word[2:0], 3'd0);
  endtask

  task automatic t_read();
    drive(1, 3'd3, 0, 0, 0, 0);
    @(negedge clk); cpu_rd = 1;
    @(posedge clk); #1;
    cpu_rd = 0;
    @(negedge clk);
    chk3("R4 main after read", status_word[2:0], 3'd7);
    chk3("R4 data after read", status_word[8:6], 3'd7);
  endtask

  task automatic t_read_pre();
    drive(1, 3'd5, 0, 0, 0, 0);
    @(negedge clk); cpu_rd = 1;
    #1 chk3("R4 pre-read value visible", status_word[2:0], 3'd5);
    @(negedge clk); cpu_rd = 0;
    chk3("R4 post-read idle", status_word[2:0], 3'd7);
  endtask

  task automatic t_collide();
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 3'd6, 0, 0, 0, 0);
    chk3("R6 data code set", status_word[8:6], 3'd6);
    drive(1, 3'd4, 0, 0, 1, 0);
    chk3("R5 event beats read", status_word[2:0], 3'd4);
    chk3("R5 other code read-reset", status_word[8:6], 3'd7);
  endtask

  task automatic t_dphase();
    drive(0, 0, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 3'd3, 0, 0, 0, 0);
    chk3("R6 data code gets event", status_word[8:6], 3'd3);
    chk3("R6 main unchanged", status_word[2:0], 3'd0);
    drive(1, 3'd1, 0, 0, 0, 0);
    chk3("R6 next event to main", status_word[2:0], 3'd1);
    chk3("R6 data code kept", status_word[8:6], 3'd3);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 1, 0, 0);
    chk3("R6 ok routed to data", status_word[8:6], 3'd0);
  endtask

  task automatic t_fixed();
    drive(1, 3'd1, 1, 0, 0, 0);
    chk3("R7 fixed stuff is form", status_word[2:0], 3'd2);
    drive(1, 3'd1, 0, 0, 0, 0);
    chk3("R7 plain stuff", status_word[2:0], 3'd1);
    drive(1, 3'd6, 1, 0, 0, 0);
    chk3("R7 flag ignored for CRC", status_word[2:0], 3'd6);
  endtask

  task automatic t_act();
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); node_act = 2'(a); err_passive = a[0];
      @(negedge clk);
      chk("R8 activity/passive", {7'd0, status_word[4:3]}, {7'd0, 2'(a)});
      chk("R8 passive bit", {8'd0, status_word[5]}, {8'd0, a[0]});
    end
  endtask

  task automatic t_ignore();
    drive(1, 3'd5, 0, 0, 0, 0);
    drive(1, 3'd0, 0, 0, 0, 0);
    chk3("R9 code 0 ignored", status_word[2:0], 3'd5);
    drive(1, 3'd7, 0, 0, 0, 0);
    chk3("R9 code 7 ignored", status_word[2:0], 3'd5);
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 3'd0, 0, 0, 0, 0);
    drive(1, 3'd2, 0, 0, 0, 0);
    chk3("R9 routing not consumed", status_word[8:6], 3'd2);
    chk3("R9 main untouched", status_word[2:0], 3'd5);
  endtask

  task automatic t_both();
    drive(1, 3'd4, 0, 1, 0, 0);
    chk3("R10 error wins over ok", status_word[2:0], 3'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_ok();
    t_read();
    t_read_pre();
    t_collide();
    t_dphase();
    t_fixed();
    t_act();
    t_ignore();
    t_both();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule